// File: doc/BRIEF.md
# Integer to Double Converter

This block turns a 64-bit integer operand into a binary64 floating-point value. A 2-bit type code selects how the operand is read: as a signed or unsigned quantity, 32 or 64 bits wide. A precision select chooses between a full double result and a value first rounded to single precision and then carried in double format. It serves a floating-point unit that moves integer data from the general register file into the floating-point register file in one step.

Every conversion that can lose bits is rounded under a 2-bit rounding mode. It reports whether rounding raised the magnitude, whether the result is inexact, and a 5-bit class code. An inexact result also sets two sticky bits: one for inexact and one summary bit. The conversion of a 32-bit integer to full double is always exact. On that path the result is written but every status output keeps its earlier value. One request can enter per cycle, and its result appears on the next cycle.

Top module: `int2dbl_conv`

## Requirements
- R1: Type code 0 reads the operand as signed 32-bit, 1 as unsigned 32-bit, 2 as signed 64-bit and 3 as unsigned 64-bit. The 32-bit types use only the least significant 32 operand bits, and an unsigned type never yields a negative result.
- R2: A request accepted with `in_valid` high gives `out_valid` high and its result on the next clock. `out_valid` is low in every other cycle.
- R3: A 32-bit type converted with `in_single` low gives the exact double. `frac_rounded`, `frac_inexact` and `result_class` keep their previous values.
- R4: All other conversions round under `in_rmode`: 00 to nearest with ties to even, 01 toward zero, 10 toward +infinity, 11 toward -infinity. A carry out of the significand moves the value up one binade.
- R5: On a rounding conversion, `frac_rounded` is 1 exactly when the rounded magnitude exceeds the exact magnitude, and `frac_inexact` is 1 exactly when the two differ. `frac_rounded` is never 1 while `frac_inexact` is 0.
- R6: An inexact rounding conversion sets `inexact_sticky` and `summary_sticky`. Both stay set until reset.
- R7: With `in_single` high, the value is rounded to a 24-bit significand and given in double format. The exponent is rebiased by 1023, and result bits 28..0 are zero.
- R8: `result_class` is 5'b00010 for +0, 5'b00100 for a positive normal value and 5'b01000 for a negative normal value.
- R9: An integer zero gives +0.0 (all 64 bits zero). On a rounding conversion it also gives class +0 with both fraction flags clear.
- R10: The most negative signed 64-bit value converts exactly to -2^63 (64'hC3E0000000000000).
- R11: While reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Request strobe |
| in_operand | input | 64 | Integer operand |
| in_kind | input | 2 | Integer type code (R1) |
| in_single | input | 1 | 1: round to single precision, held in double format |
| in_rmode | input | 2 | Rounding mode (R4) |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_result | output | 64 | binary64 result |
| frac_rounded | output | 1 | Rounding increased the magnitude |
| frac_inexact | output | 1 | Result is inexact |
| result_class | output | 5 | Result class code (R8) |
| inexact_sticky | output | 1 | Sticky inexact bit |
| summary_sticky | output | 1 | Sticky summary exception bit |

## Verification
Fixed operands anchor the type decoding. These include a 32-bit value whose upper word is junk, signed and unsigned all-ones patterns, the most negative 64-bit integer and zero, each checked against its literal double encoding. All-ones 64-bit and 2^24+1 operands form exact ties and full-carry cases, and they show the four rounding modes apart in both precisions. A pseudo-random stream spreads the leading one across every bit position and mixes all type codes, modes and precisions. It interleaves exact 32-bit conversions between rounding ones, so a status output that changes on the exact path shows up against the expected held value.

// File: rtl/int2dbl_pkg.sv
package int2dbl_pkg;

  localparam int INT_W    = 64;
  localparam int DBL_PREC = 53;
  localparam int SGL_PREC = 24;
  localparam int EXP_W    = 11;
  localparam int DBL_BIAS = 1023;
  localparam int CLS_W    = 5;

  localparam logic [CLS_W-1:0] CLS_POS_ZERO = 5'b00010;
  localparam logic [CLS_W-1:0] CLS_POS_NORM = 5'b00100;
  localparam logic [CLS_W-1:0] CLS_NEG_NORM = 5'b01000;

  typedef enum logic [1:0] {
    KIND_S32 = 2'd0,
    KIND_U32 = 2'd1,
    KIND_S64 = 2'd2,
    KIND_U64 = 2'd3
  } int_kind_e;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'd0,
    RM_ZERO      = 2'd1,
    RM_POS_INF   = 2'd2,
    RM_NEG_INF   = 2'd3
  } rnd_mode_e;

endpackage

// File: rtl/i2d_magnitude.sv
module i2d_magnitude
  import int2dbl_pkg::*;
#(
  parameter int W = INT_W
) (
  input  logic [W-1:0] operand_i,
  input  logic [1:0]   kind_i,
  output logic         neg_o,
  output logic [W-1:0] mag_o
);
  localparam int HALF = W / 2;

  logic [HALF-1:0] low_word;
  logic [W-1:0]    extended;
  logic            is_signed;

  always_comb begin
    low_word  = operand_i[HALF-1:0];
    is_signed = ~kind_i[0];
    if (kind_i[1]) begin
      extended = operand_i;
    end else if (kind_i[0]) begin
      extended = {{HALF{1'b0}}, low_word};
    end else begin
      extended = {{HALF{low_word[HALF-1]}}, low_word};
    end
    neg_o = is_signed & extended[W-1];
    mag_o = neg_o ? (~extended + W'(1)) : extended;
  end
endmodule

// File: rtl/i2d_normalize.sv
module i2d_normalize
  import int2dbl_pkg::*;
#(
  parameter int W = INT_W
) (
  input  logic [W-1:0]         mag_i,
  output logic [W-1:0]         norm_o,
  output logic [$clog2(W)-1:0] msb_o,
  output logic                 zero_o
);
  localparam int POS_W = $clog2(W);

  logic [POS_W-1:0] lead_pos;
  logic [POS_W-1:0] lz_count;

  // Priority scan: the highest set bit wins.
  always_comb begin
    lead_pos = '0;
    for (int i = 0; i < W; i++) begin
      if (mag_i[i]) lead_pos = POS_W'(i);
    end
    lz_count = POS_W'(W - 1) - lead_pos;
    norm_o   = mag_i << lz_count;
    msb_o    = lead_pos;
    zero_o   = ~|mag_i;
  end
endmodule

// File: rtl/i2d_round.sv
module i2d_round
  import int2dbl_pkg::*;
#(
  parameter int W    = INT_W,
  parameter int PREC = DBL_PREC
) (
  input  logic [W-1:0]    norm_i,
  input  logic            neg_i,
  input  logic [1:0]      rmode_i,
  output logic [PREC-1:0] mant_o,
  output logic            carry_o,
  output logic            up_o,
  output logic            inexact_o
);
  localparam int REST_W = W - PREC - 1;

  logic [PREC-1:0] kept;
  logic            guard_bit;
  logic            sticky_bit;
  logic [PREC:0]   sum;

  always_comb begin
    kept       = norm_i[W-1 -: PREC];
    guard_bit  = norm_i[REST_W];
    sticky_bit = |norm_i[REST_W-1:0];
    inexact_o  = guard_bit | sticky_bit;
    case (rnd_mode_e'(rmode_i))
      RM_NEAR_EVEN: up_o = guard_bit & (sticky_bit | kept[0]);
      RM_ZERO:      up_o = 1'b0;
      RM_POS_INF:   up_o = inexact_o & ~neg_i;
      default:      up_o = inexact_o & neg_i;
    endcase
    sum     = {1'b0, kept} + (PREC+1)'(up_o);
    carry_o = sum[PREC];
    mant_o  = carry_o ? {1'b1, {(PREC-1){1'b0}}} : sum[PREC-1:0];
  end
endmodule

// File: rtl/int2dbl_conv.sv
module int2dbl_conv
  import int2dbl_pkg::*;
#(
  parameter int W = INT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [W-1:0]     in_operand,
  input  logic [1:0]       in_kind,
  input  logic             in_single,
  input  logic [1:0]       in_rmode,
  output logic             out_valid,
  output logic [W-1:0]     out_result,
  output logic             frac_rounded,
  output logic             frac_inexact,
  output logic [CLS_W-1:0] result_class,
  output logic             inexact_sticky,
  output logic             summary_sticky
);
  localparam int POS_W    = $clog2(W);
  localparam int PAD_W    = DBL_PREC - SGL_PREC;
  localparam int DFRAC_W  = DBL_PREC - 1;
  localparam int SFRAC_W  = SGL_PREC - 1;

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  // Datapath
  logic             neg;
  logic [W-1:0]     mag;
  logic [W-1:0]     norm;
  logic [POS_W-1:0] msb;
  logic             is_zero;

  i2d_magnitude #(.W(W)) u_mag (
    .operand_i (in_operand),
    .kind_i    (in_kind),
    .neg_o     (neg),
    .mag_o     (mag)
  );

  i2d_normalize #(.W(W)) u_norm (
    .mag_i  (mag),
    .norm_o (norm),
    .msb_o  (msb),
    .zero_o (is_zero)
  );

  logic [DBL_PREC-1:0] mant_d;
  logic                cy_d, up_d, inx_d;
  logic [SGL_PREC-1:0] mant_s;
  logic                cy_s, up_s, inx_s;

  i2d_round #(.W(W), .PREC(DBL_PREC)) u_rnd_dbl (
    .norm_i    (norm),
    .neg_i     (neg),
    .rmode_i   (in_rmode),
    .mant_o    (mant_d),
    .carry_o   (cy_d),
    .up_o      (up_d),
    .inexact_o (inx_d)
  );

  i2d_round #(.W(W), .PREC(SGL_PREC)) u_rnd_sgl (
    .norm_i    (norm),
    .neg_i     (neg),
    .rmode_i   (in_rmode),
    .mant_o    (mant_s),
    .carry_o   (cy_s),
    .up_o      (up_s),
    .inexact_o (inx_s)
  );

  // Result packing and classification
  logic [EXP_W-1:0] exp_biased;
  logic [W-1:0]     result_d;
  logic             rnd_up, rnd_inexact;
  logic             status_path;
  logic [CLS_W-1:0] class_d;

  always_comb begin
    rnd_up      = in_single ? up_s  : up_d;
    rnd_inexact = in_single ? inx_s : inx_d;
    exp_biased  = EXP_W'(DBL_BIAS) + EXP_W'(msb)
                + EXP_W'(in_single ? cy_s : cy_d);
    if (is_zero) begin
      result_d = '0;
    end else if (in_single) begin
      result_d = {neg, exp_biased, mant_s[SFRAC_W-1:0], {PAD_W{1'b0}}};
    end else begin
      result_d = {neg, exp_biased, mant_d[DFRAC_W-1:0]};
    end
    if (is_zero)  class_d = CLS_POS_ZERO;
    else if (neg) class_d = CLS_NEG_NORM;
    else          class_d = CLS_POS_NORM;
    // Only 32-bit integers to full double skip the status update.
    status_path = in_kind[1] | in_single;
  end

  // Next-state logic
  logic             valid_n, fr_n, fi_n, xx_n, fx_n;
  logic [W-1:0]     result_n;
  logic [CLS_W-1:0] class_n;
  logic             result_en, status_en;

  always_comb begin
    result_en = in_valid;
    status_en = in_valid & status_path;
    valid_n   = in_valid;
    result_n  = result_d;
    fr_n      = rnd_up;
    fi_n      = rnd_inexact;
    class_n   = class_d;
    xx_n      = inexact_sticky | rnd_inexact;
    fx_n      = summary_sticky | rnd_inexact;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= valid_n;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_result <= '0;
    end else if (result_en) begin
      out_result <= result_n;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      frac_rounded   <= 1'b0;
      frac_inexact   <= 1'b0;
      result_class   <= '0;
      inexact_sticky <= 1'b0;
      summary_sticky <= 1'b0;
    end else if (status_en) begin
      frac_rounded   <= fr_n;
      frac_inexact   <= fi_n;
      result_class   <= class_n;
      inexact_sticky <= xx_n;
      summary_sticky <= fx_n;
    end
  end
endmodule

// File: rtl/int2dbl_conv_chk.sv
module int2dbl_conv_chk
  import int2dbl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [63:0]      in_operand,
  input logic [1:0]       in_kind,
  input logic             in_single,
  input logic             out_valid,
  input logic [63:0]      out_result,
  input logic             frac_rounded,
  input logic             frac_inexact,
  input logic [CLS_W-1:0] result_class,
  input logic             inexact_sticky,
  input logic             summary_sticky
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_UNSIGNED_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind[0]) |=> !out_result[63]); // R1
  AST_EXACT_HOLDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_kind[1] && !in_single)
      |=> ($stable(frac_rounded) && $stable(frac_inexact) && $stable(result_class))); // R3
  AST_ROUNDED_IMPLIES_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    frac_rounded |-> frac_inexact); // R5
  AST_INEXACT_IS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    frac_inexact |-> inexact_sticky); // R6
  AST_STICKY_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(inexact_sticky)); // R6
  AST_SUMMARY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    inexact_sticky |-> summary_sticky); // R6
  AST_SINGLE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_single) |=> (out_result[28:0] == 29'd0)); // R7
  AST_MIN_S64_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 2'd2 && !in_single && in_operand == 64'h8000_0000_0000_0000)
      |=> (out_result == 64'hC3E0_0000_0000_0000)); // R10
endmodule

bind int2dbl_conv int2dbl_conv_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_q_n),
  .in_valid       (in_valid),
  .in_operand     (in_operand),
  .in_kind        (in_kind),
  .in_single      (in_single),
  .out_valid      (out_valid),
  .out_result     (out_result),
  .frac_rounded   (frac_rounded),
  .frac_inexact   (frac_inexact),
  .result_class   (result_class),
  .inexact_sticky (inexact_sticky),
  .summary_sticky (summary_sticky)
);

// File: tb/int2dbl_conv_test.sv
`timescale 1ns/1ps
module int2dbl_conv_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_operand;
  logic [1:0]  in_kind;
  logic        in_single;
  logic [1:0]  in_rmode;
  logic        out_valid;
  logic [63:0] out_result;
  logic        frac_rounded, frac_inexact;
  logic [4:0]  result_class;
  logic        inexact_sticky, summary_sticky;

  always #5 clk = ~clk;

  int2dbl_conv uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
    .in_kind(in_kind), .in_single(in_single), .in_rmode(in_rmode),
    .out_valid(out_valid), .out_result(out_result),
    .frac_rounded(frac_rounded), .frac_inexact(frac_inexact),
    .result_class(result_class), .inexact_sticky(inexact_sticky),
    .summary_sticky(summary_sticky)
  );

  typedef struct {
    logic [63:0] res;
    bit          fr, fi, xx, fx;
    logic [4:0]  cls;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad   = 0;
  bit   m_fr = 0, m_fi = 0, m_xx = 0, m_fx = 0;
  logic [4:0] m_cls = 5'd0;

  // Independent reference: bit scan plus remainder comparison.
  function automatic void ref_conv(input logic [63:0] op, input logic [1:0] kind,
                                   input bit sgl, input logic [1:0] rm,
                                   output logic [63:0] res, output bit up,
                                   output bit inx, output logic [4:0] cls);
    logic [63:0] v, mag, kept, rem, half;
    bit neg;
    int p, prec, sh;
    case (kind)
      2'd0: v = {{32{op[31]}}, op[31:0]};
      2'd1: v = {32'd0, op[31:0]};
      default: v = op;
    endcase
    neg = (kind[0] == 1'b0) && v[63];
    mag = neg ? (64'd0 - v) : v;
    up = 0; inx = 0;
    if (mag == 64'd0) begin
      res = 64'd0; cls = 5'b00010; return;
    end
    cls = neg ? 5'b01000 : 5'b00100;
    p = 0;
    for (int i = 0; i < 64; i++) if (mag[i]) p = i;
    prec = sgl ? 24 : 53;
    if (p < prec) begin
      kept = mag << (prec - 1 - p);
    end else begin
      sh   = p - prec + 1;
      kept = mag >> sh;
      rem  = mag & ((64'd1 << sh) - 64'd1);
      half = 64'd1 << (sh - 1);
      inx  = (rem != 64'd0);
      case (rm)
        2'd0: up = (rem > half) || ((rem == half) && kept[0]);
        2'd1: up = 0;
        2'd2: up = inx && !neg;
        default: up = inx && neg;
      endcase
      if (up) kept = kept + 64'd1;
      if (kept == (64'd1 << prec)) begin
        kept = kept >> 1; p = p + 1;
      end
    end
    if (sgl) res = {neg, 11'(p + 1023), kept[22:0], 29'd0};
    else     res = {neg, 11'(p + 1023), kept[51:0]};
  endfunction

  task automatic drive(input logic [63:0] op, input logic [1:0] kind, input bit sgl,
                       input logic [1:0] rm, input bit use_lit,
                       input logic [63:0] lit, input string tag);
    exp_t e;
    logic [63:0] r;
    bit up, inx;
    logic [4:0] cls;
    @(negedge clk);
    in_valid = 1'b1; in_operand = op; in_kind = kind; in_single = sgl; in_rmode = rm;
    ref_conv(op, kind, sgl, rm, r, up, inx, cls);
    if (kind[1] || sgl) begin
      m_fr = up; m_fi = inx; m_cls = cls;
      m_xx = m_xx | inx; m_fx = m_fx | inx;
    end
    e.res = use_lit ? lit : r;
    e.fr = m_fr; e.fi = m_fi; e.cls = m_cls; e.xx = m_xx; e.fx = m_fx;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: compares each result in the cycle it appears.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      total++;
      if (q.size() == 0) begin
        bad++;
        $display("FAIL R2 unexpected out_valid actual=1 expected=0");
      end else begin
        exp_t e;
        e = q.pop_front();
        if (out_result !== e.res || frac_rounded !== e.fr || frac_inexact !== e.fi ||
            result_class !== e.cls || inexact_sticky !== e.xx || summary_sticky !== e.fx) begin
          bad++;
          $display("FAIL %s actual res=%h fr=%0d fi=%0d cls=%b xx=%0d fx=%0d expected res=%h fr=%0d fi=%0d cls=%b xx=%0d fx=%0d",
                   e.tag, out_result, frac_rounded, frac_inexact, result_class,
                   inexact_sticky, summary_sticky, e.res, e.fr, e.fi, e.cls, e.xx, e.fx);
        end
      end
    end
  end

  initial begin
    int cycles = 0;
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_operand = '0; in_kind = '0;
    in_single = 1'b0; in_rmode = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    total++;
    if ({out_valid, out_result, frac_rounded, frac_inexact, result_class,
         inexact_sticky, summary_sticky} !== '0) begin
      bad++;
      $display("FAIL R11 reset outputs actual=%h expected=0", out_result);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R3: exact 32-bit conversions, upper word ignored
    drive(64'h1234_5678_0000_0005, 2'd0, 0, 2'd0, 1, 64'h4014_0000_0000_0000, "R1 s32 upper ignored");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 0, 2'd2, 1, 64'hBFF0_0000_0000_0000, "R1 s32 minus one");
    drive(64'hABCD_0000_FFFF_FFFF, 2'd1, 0, 2'd3, 1, 64'h41EF_FFFF_FFE0_0000, "R3 u32 all ones exact");
    drive(64'h0000_0000_0000_0001, 2'd3, 0, 2'd0, 1, 64'h3FF0_0000_0000_0000, "R1 u64 one");
    // R4 / R5: full carry versus truncation
    drive(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 0, 2'd0, 1, 64'h43F0_0000_0000_0000, "R4 u64 max nearest");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 0, 2'd1, 1, 64'h43EF_FFFF_FFFF_FFFF, "R4 u64 max toward zero");
    // R3: exact path after a rounding one keeps the flags
    drive(64'h0000_0000_8000_0000, 2'd0, 0, 2'd0, 1, 64'hC1E0_0000_0000_0000, "R3 s32 min holds flags");
    // R10
    drive(64'h8000_0000_0000_0000, 2'd2, 0, 2'd3, 1, 64'hC3E0_0000_0000_0000, "R10 s64 min");
    // R9 / R8
    drive(64'h0000_0000_0000_0000, 2'd3, 0, 2'd2, 1, 64'h0000_0000_0000_0000, "R9 zero");
    drive(64'h0000_0000_0000_0000, 2'd1, 1, 2'd0, 1, 64'h0000_0000_0000_0000, "R9 zero single");
    // R7: single-precision ties and directed rounding
    drive(64'h0000_0000_0100_0001, 2'd1, 1, 2'd0, 1, 64'h4170_0000_0000_0000, "R7 single tie even");
    drive(64'h0000_0000_0100_0001, 2'd1, 1, 2'd2, 1, 64'h4170_0000_2000_0000, "R7 single up");
    drive(64'hFFFF_FFFF_FEFF_FFFF, 2'd2, 1, 2'd3, 1, 64'hC170_0000_2000_0000, "R7 single negative down");
    drive(64'hFFFF_FFFF_FEFF_FFFF, 2'd2, 1, 2'd1, 1, 64'hC170_0000_0000_0000, "R7 single negative zero-mode");
    drive(64'h0000_0000_0000_0003, 2'd2, 1, 2'd0, 1, 64'h4008_0000_0000_0000, "R8 single small exact");
    idle();

    // R4 / R5 / R6 / R8: pseudo-random sweep
    for (int n = 0; n < 600; n++) begin
      logic [63:0] op;
      op = {$urandom, $urandom} >> ($urandom % 64);
      if (n % 7 == 3) op = 0 - op;
      drive(op, 2'($urandom), 1'($urandom), 2'($urandom), 0, 64'd0, "R4 random");
      if (n % 50 == 49) idle();
    end
    idle();
    repeat (4) @(negedge clk);
    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R2 missing results actual=%0d expected=0", q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule